// File: doc/BRIEF.md
# Flash Page ECC Syndrome Corrector

This block compares the 24-bit error-correcting code kept in the spare area of a flash page with the 24-bit code recomputed over the page's 512 data bytes. It then classifies the outcome. The XOR of the two codes forms a syndrome. When the syndrome points at a single flipped data bit, the block decodes where that bit sits: a 9-bit byte position and a 3-bit bit position. It also separates four other cases: a clean page, a flip inside the stored code itself, a page whose stored code was never programmed, and damage it cannot repair.

A code pair is presented with a one-cycle valid strobe. The verdict and the location appear one clock later and stay put until the next pair arrives. A combinational replay port lets the caller stream the page bytes back through the block with their positions. The byte at the decoded position comes out with the faulty bit inverted, and every other byte passes through unchanged.

Top module: `nand_ecc_fixer`

## Requirements
- R1: When the stored and computed codes are equal, the status is CLEAN (code 0) and both location outputs read zero.
- R2: When the stored code is 24'hFFFFFF and the syndrome is nonzero, the status is SKIPPED (code 3), even if the syndrome would otherwise be correctable. The location outputs read zero and the replay stream is not modified.
- R3: A syndrome counts as a correctable data error, with status DATA_FIXED (code 1), only when every bit pair {s[2p+1], s[2p]} of the 24-bit syndrome s differs, for p = 0..11.
- R4: For DATA_FIXED, the byte position is {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]}, most significant bit first.
- R5: For DATA_FIXED, the bit position is {s[23], s[21], s[19]}, most significant bit first.
- R6: A syndrome with exactly one bit set gives status CODE_ERR (code 2). The location outputs read zero and the replay stream is not modified.
- R7: Any other nonzero syndrome, such as two flipped code bits or two flipped data bits, gives status UNCORRECTABLE (code 4).
- R8: The verdict and location appear on the clock edge that samples the input valid. The output valid is high for exactly that one cycle, and the verdict is held unchanged until the next input.
- R9: While the held status is DATA_FIXED, a replay byte whose position equals the byte position leaves with bit (bit position) inverted. Any other replay byte, or any byte under any other status, passes through unchanged.
- R10: After reset, the status is CLEAN, the output valid is low and the location outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Qualifies storedCode and calcCode for one cycle |
| storedCode | input | 24 | Code read from the page spare area, byte 0 in bits 7:0 |
| calcCode | input | 24 | Code recomputed over the page data, same byte order |
| outValid | output | 1 | One-cycle strobe marking a new verdict |
| status | output | 3 | 0 CLEAN, 1 DATA_FIXED, 2 CODE_ERR, 3 SKIPPED, 4 UNCORRECTABLE |
| byteIdx | output | 9 | Position of the faulty data byte within the page |
| bitIdx | output | 3 | Position of the faulty bit within that byte |
| streamPos | input | 9 | Position of the byte currently being replayed |
| streamByte | input | 8 | Replayed data byte |
| fixedByte | output | 8 | Replayed byte after correction |

## Verification
The bench injects every single-bit flip across all 4096 data bits of a page. A wrong scatter map would show up as a wrong byte or bit position, and a pair test that was too loose or too tight would misclassify some of these flips. Every single flip of the 24 code bits is also applied; a design that fed these through the location decoder would report a bogus data repair. Double flips in the code and in the data must come out uncorrectable. Unprogrammed-code pages carrying otherwise repairable syndromes must be skipped; a design that tested the priority in the wrong order would corrupt data there. The replay port is checked at the decoded byte and at a neighbouring byte, to catch an off-by-one match or a correction left armed under the wrong status.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  // Verdict encodings; the values are visible on the status port.
  typedef enum logic [2:0] {
    ST_CLEAN      = 3'd0,
    ST_DATA_FIXED = 3'd1,
    ST_CODE_ERR   = 3'd2,
    ST_SKIPPED    = 3'd3,
    ST_UNCORR     = 3'd4
  } fixStatus_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadIdx;   // capture the decoded location
    logic clearIdx;  // zero the location registers
    logic armFix;    // replay correction enabled
  } dpStrobe_t;

  // Syndrome features from datapath to control.
  typedef struct packed {
    logic synZero;
    logic storedBlank;
    logic pairsOk;
    logic synSingle;
  } dpFlags_t;

endpackage

// File: rtl/ecc_fix_dpath.sv
module ecc_fix_dpath
  import ecc_fix_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int CODE_LANES = 3,
  parameter int POS_W      = 9,
  parameter int HAS_FIX    = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LANE_W*CODE_LANES-1:0] storedCode,
  input  logic [LANE_W*CODE_LANES-1:0] calcCode,
  input  dpStrobe_t                    stb,
  output dpFlags_t                     flags,
  output logic [POS_W-1:0]             byteIdx,
  output logic [$clog2(LANE_W)-1:0]    bitIdx,
  input  logic [POS_W-1:0]             streamPos,
  input  logic [LANE_W-1:0]            streamByte,
  output logic [LANE_W-1:0]            fixedByte
);

  localparam int CODE_W = LANE_W * CODE_LANES;
  localparam int PAIRS  = CODE_W / 2;
  localparam int BIT_W  = $clog2(LANE_W);

  logic [CODE_W-1:0] syn;
  logic [PAIRS-1:0]  pairDiff;
  logic [PAIRS-1:0]  pairVal;
  logic [POS_W-1:0]  nextByte;
  logic [BIT_W-1:0]  nextBit;
  logic [POS_W-1:0]  byteQ;
  logic [BIT_W-1:0]  bitQ;

  assign syn = storedCode ^ calcCode;

  // Each syndrome pair carries one location bit in its odd member.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pairDiff[p] = syn[2*p] ^ syn[2*p+1];
    assign pairVal[p]  = syn[2*p+1];
  end

  always_comb begin
    flags.synZero     = ~|syn;
    flags.storedBlank = &storedCode;
    flags.pairsOk     = &pairDiff;
    flags.synSingle   = ($countones(syn) == 1);
  end

  // The lower pairs give the byte position, the upper ones the bit position.
  assign nextByte = pairVal[POS_W-1:0];
  assign nextBit  = pairVal[POS_W+BIT_W-1:POS_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteQ <= '0;
      bitQ  <= '0;
    end else if (stb.loadIdx) begin
      byteQ <= nextByte;
      bitQ  <= nextBit;
    end else if (stb.clearIdx) begin
      byteQ <= '0;
      bitQ  <= '0;
    end
  end

  assign byteIdx = byteQ;
  assign bitIdx  = bitQ;

  if (HAS_FIX != 0) begin : g_fix
    logic             hit;
    logic [LANE_W-1:0] flipMask;
    assign hit      = stb.armFix && (streamPos == byteQ);
    assign flipMask = hit ? (LANE_W'(1) << bitQ) : '0;
    assign fixedByte = streamByte ^ flipMask;
  end else begin : g_nofix
    assign fixedByte = streamByte;
  end

  // R3: a location is only captured for a syndrome with every pair split
  assert_fix_needs_pairs_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadIdx |-> (flags.pairsOk && !flags.storedBlank));

  // R8: the location holds while no new input arrives
  assert_idx_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadIdx && !stb.clearIdx) |=> ($stable(byteIdx) && $stable(bitIdx)));

  // R9: the replay path never alters more than one bit
  assert_single_flip_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(fixedByte ^ streamByte) <= 1);

  // R9: no flip unless the correction is armed
  assert_no_flip_unarmed_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.armFix |-> (fixedByte == streamByte));

endmodule

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  dpFlags_t   flags,
  output dpStrobe_t  stb,
  output logic [2:0] status,
  output logic       outValid
);

  fixStatus_t nextStatus;
  fixStatus_t statusQ;
  logic       validQ;

  // Priority: clean, unprogrammed, data repair, code flip, failure.
  always_comb begin
    if (flags.synZero)           nextStatus = ST_CLEAN;
    else if (flags.storedBlank)  nextStatus = ST_SKIPPED;
    else if (flags.pairsOk)      nextStatus = ST_DATA_FIXED;
    else if (flags.synSingle)    nextStatus = ST_CODE_ERR;
    else                         nextStatus = ST_UNCORR;
  end

  always_comb begin
    stb.loadIdx  = inValid && (nextStatus == ST_DATA_FIXED);
    stb.clearIdx = inValid && (nextStatus != ST_DATA_FIXED);
    stb.armFix   = (statusQ == ST_DATA_FIXED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= ST_CLEAN;
      validQ  <= 1'b0;
    end else begin
      validQ <= inValid;
      if (inValid) statusQ <= nextStatus;
    end
  end

  assign status   = statusQ;
  assign outValid = validQ;

  // R1: a clean verdict requires a zero syndrome at the sampled input
  assert_clean_from_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && flags.synZero) |=> (status == ST_CLEAN));

  // R2: an unprogrammed code with a nonzero syndrome is skipped
  assert_blank_skipped_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && flags.storedBlank && !flags.synZero) |=> (status == ST_SKIPPED));

  // R6: a one-bit syndrome is charged to the code bytes
  assert_code_flip_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && flags.synSingle && !flags.storedBlank) |=> (status == ST_CODE_ERR));

  // R8: the output strobe lasts one cycle per input strobe
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !inValid) |=> !outValid);

  // R8: the verdict is held between inputs
  assert_status_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(status));

endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import ecc_fix_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int CODE_LANES = 3,
  parameter int POS_W      = 9,
  parameter int HAS_FIX    = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [LANE_W*CODE_LANES-1:0] storedCode,
  input  logic [LANE_W*CODE_LANES-1:0] calcCode,
  output logic                         outValid,
  output logic [2:0]                   status,
  output logic [POS_W-1:0]             byteIdx,
  output logic [$clog2(LANE_W)-1:0]    bitIdx,
  input  logic [POS_W-1:0]             streamPos,
  input  logic [LANE_W-1:0]            streamByte,
  output logic [LANE_W-1:0]            fixedByte
);

  dpStrobe_t stb;
  dpFlags_t  flags;

  ecc_fix_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .flags    (flags),
    .stb      (stb),
    .status   (status),
    .outValid (outValid)
  );

  ecc_fix_dpath #(
    .LANE_W     (LANE_W),
    .CODE_LANES (CODE_LANES),
    .POS_W      (POS_W),
    .HAS_FIX    (HAS_FIX)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .storedCode (storedCode),
    .calcCode   (calcCode),
    .stb        (stb),
    .flags      (flags),
    .byteIdx    (byteIdx),
    .bitIdx     (bitIdx),
    .streamPos  (streamPos),
    .streamByte (streamByte),
    .fixedByte  (fixedByte)
  );

endmodule

// File: tb/nand_ecc_fixer_bench.sv
`timescale 1ns/100ps
module nand_ecc_fixer_bench;

  localparam logic [2:0] S_CLEAN = 3'd0, S_FIXED = 3'd1, S_CODE = 3'd2,
                         S_SKIP = 3'd3, S_UNCORR = 3'd4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] storedCode = '0;
  logic [23:0] calcCode = '0;
  logic        outValid;
  logic [2:0]  status;
  logic [8:0]  byteIdx;
  logic [2:0]  bitIdx;
  logic [8:0]  streamPos = '0;
  logic [7:0]  streamByte = '0;
  logic [7:0]  fixedByte;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [2:0] st;
    logic [8:0] bi;
    logic [2:0] bt;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  nand_ecc_fixer u_nand_ecc_fixer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .storedCode(storedCode),
    .calcCode(calcCode), .outValid(outValid), .status(status),
    .byteIdx(byteIdx), .bitIdx(bitIdx), .streamPos(streamPos),
    .streamByte(streamByte), .fixedByte(fixedByte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Syndrome of a single data-bit flip, built from R3/R4/R5.
  function automatic logic [23:0] dataSyn(input int pos, input int bt);
    logic [23:0] s;
    logic [11:0] loc;
    loc = {bt[2:0], pos[8:0]};
    for (int p = 0; p < 12; p++) begin
      s[2*p+1] = loc[p];
      s[2*p]   = ~loc[p];
    end
    return s;
  endfunction

  // Monitor: pops an expectation for every output strobe.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected outValid", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(status == e.st, {e.tag, " status"}, status, e.st);
        check(byteIdx == e.bi, {e.tag, " byteIdx"}, byteIdx, e.bi);
        check(bitIdx == e.bt, {e.tag, " bitIdx"}, bitIdx, e.bt);
      end
    end
  end

  // Driver: one code pair, then replay and hold checks.
  task automatic run(input logic [23:0] s, input logic [23:0] c, input logic [2:0] st,
                     input logic [8:0] bi, input logic [2:0] bt, input string tag);
    exp_t e;
    logic [7:0] want;
    e.st = st; e.bi = bi; e.bt = bt; e.tag = tag;
    @(negedge clk);
    storedCode = s; calcCode = c; inValid = 1'b1;
    expQ.push_back(e);
    @(negedge clk);
    inValid = 1'b0;
    storedCode = 24'($urandom); calcCode = 24'($urandom);
    #0.5;
    streamByte = 8'h5A; streamPos = bi;
    #0.5;
    want = (st == S_FIXED) ? (8'h5A ^ (8'd1 << bt)) : 8'h5A;
    check(fixedByte == want, {"R9 ", tag, " replay at position"}, fixedByte, want);
    streamPos = bi ^ 9'd1;
    #0.5;
    check(fixedByte == 8'h5A, {"R9 ", tag, " replay neighbour"}, fixedByte, 8'h5A);
    @(negedge clk);
    check(!outValid && status == st && byteIdx == bi,
          {"R8 ", tag, " held"}, {outValid, status, byteIdx}, {1'b0, st, bi});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] s;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(status == S_CLEAN && !outValid && byteIdx == 0 && bitIdx == 0,
          "R10 reset", {status, outValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(status == S_CLEAN && !outValid, "R10 after release", status, 0);

    // R1: matching codes
    run(24'h123456, 24'h123456, S_CLEAN, 0, 0, "R1 equal");
    run(24'hFFFFFF, 24'hFFFFFF, S_CLEAN, 0, 0, "R1 blank equal");
    run(24'h000000, 24'h000000, S_CLEAN, 0, 0, "R1 zero");

    // R3 R4 R5: every data bit of a page
    for (int pos = 0; pos < 512; pos++) begin
      for (int bt = 0; bt < 8; bt++) begin
        s = 24'($urandom) & 24'hFFFFFE;
        run(s, s ^ dataSyn(pos, bt), S_FIXED, 9'(pos), 3'(bt), "R4 R5 data flip");
      end
    end

    // R6: every single code bit
    for (int i = 0; i < 24; i++) begin
      s = 24'($urandom) & 24'hFFFEFF;
      run(s, s ^ (24'd1 << i), S_CODE, 0, 0, "R6 code flip");
    end

    // R7: double code flips and double data flips
    for (int i = 0; i < 24; i++) begin
      s = 24'h0F0F0F;
      run(s, s ^ (24'd1 << i) ^ (24'd1 << ((i + 5) % 24)), S_UNCORR, 0, 0, "R7 two code bits");
    end
    run(24'h13579B, 24'h13579B ^ dataSyn(3, 1) ^ dataSyn(200, 6), S_UNCORR, 0, 0, "R7 two data bits");
    run(24'h2468AC, 24'h2468AC ^ dataSyn(511, 7) ^ dataSyn(511, 0), S_UNCORR, 0, 0, "R7 same byte");

    // R2: unprogrammed stored code
    run(24'hFFFFFF, 24'hFFFFFF ^ dataSyn(10, 3), S_SKIP, 0, 0, "R2 blank correctable");
    run(24'hFFFFFF, 24'hFFFFFE, S_SKIP, 0, 0, "R2 blank single");
    run(24'hFFFFFF, 24'h00A0C3, S_SKIP, 0, 0, "R2 blank random");

    // R9/R8: repair after a non-repair, back to back
    run(24'h000000, dataSyn(77, 4), S_FIXED, 9'd77, 3'd4, "R9 repair after skip");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8 all results seen", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule